// File: doc/BRIEF.md
# Monochrome to Color Expansion Unit

The unit turns a packed one-bit-per-pixel bitmap scanline into a byte-wide mask stream for pixels that are one, two, three or four bytes deep. Every bitmap bit is copied onto as many mask bits as the pixel has bytes. A downstream byte-oriented engine then uses each mask bit to pick foreground or background for one byte of the frame buffer. Because of this, an engine that only handles 8-bit pixels can also serve 16-, 24- and 32-bit formats.

Software sets the pixel format through a small configuration port, which only takes effect between scanlines. A scanline begins with a start pulse that carries the width in pixels. The bitmap then flows in as bytes on a valid/ready stream. It is consumed in whole 32-bit words, so the last word is padded. The mask leaves as a valid/ready byte stream, and a marker flags the final byte of the scanline.

Top module: `mono_color_expander`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_last`, `busy`, `in_ready` and `cfg_reject` are low, any partial expansion is dropped, and the depth is one byte per pixel.
- R2: A configuration write with `cfg_bpp` = 8, 15, 16, 24 or 32 sets the depth to 1, 2, 2, 3 or 4 bytes per pixel respectively. Any other value is ignored and raises `cfg_reject` for one cycle.
- R3: Take an input byte v at depth B. Mask bit j·B+m (for j = 0..7 and m = 0..B-1) equals bit j of v, so bit 0 maps to the lowest pixel. The 8·B mask bits leave least-significant byte first.
- R4: Each accepted input byte yields exactly B output bytes, including B = 3, where a modulo-3 byte counter decides when the next input byte is taken.
- R5: A start pulse of width W while idle accepts exactly 4·ceil(W/32) input bytes. A width of zero starts nothing, and `busy` stays low.
- R6: `out_last` is high only on the final output byte of the final input byte of the scanline. `busy` falls after that byte is taken.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. No byte is lost or repeated.
- R8: A configuration write while `busy` is high is ignored (the line continues at the old depth) and raises `cfg_reject` the next cycle.
- R9: A start pulse while `busy` is high is ignored.
- R10: A reset in the middle of a line ends it at once. A new line afterwards is processed normally.
- R11: `in_ready` is high only while a line is busy and input bytes remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bpp | input | 6 | Requested bits per pixel |
| cfg_reject | output | 1 | Last configuration write was refused |
| line_start | input | 1 | Start a scanline |
| line_width | input | WIDTH_W | Scanline width in pixels |
| busy | output | 1 | A scanline is in progress |
| in_valid | input | 1 | Bitmap byte valid |
| in_data | input | 8 | Bitmap byte |
| in_ready | output | 1 | Bitmap byte accepted when valid |
| out_valid | output | 1 | Mask byte valid |
| out_data | output | 8 | Mask byte |
| out_last | output | 1 | Final mask byte of the scanline |
| out_ready | input | 1 | Downstream takes the mask byte |

## Verification
A wrong byte-within-pixel counter shows within one input byte. It appears as a missing or extra mask byte, or a byte from the wrong slice, and the three-byte depth exposes it fastest. A wrong input-remaining count shows only at the end of a line, as a misplaced or missing `out_last` or a `busy` that never falls. The checks therefore compare full streams and their lengths, not only the first bytes. A depth register that changes while busy shows on the very next input byte, as a changed output count per byte.

// File: rtl/mce_pkg.sv
package mce_pkg;
   localparam int MAX_BYTES = 4;
   localparam int MASK_BITS = 8 * MAX_BYTES;

   // depth code = bytes per pixel minus one
   typedef enum logic [1:0] {
      DEP_1B = 2'd0,
      DEP_2B = 2'd1,
      DEP_3B = 2'd2,
      DEP_4B = 2'd3
   } depth_e;

   typedef struct packed {
      logic   ok;
      depth_e code;
   } bpp_dec_t;

   function automatic bpp_dec_t decode_bpp(input logic [5:0] bpp);
      bpp_dec_t r;
      r.ok = 1'b1;
      unique case (bpp)
         6'd8:          r.code = DEP_1B;
         6'd15, 6'd16:  r.code = DEP_2B;
         6'd24:         r.code = DEP_3B;
         6'd32:         r.code = DEP_4B;
         default: begin
            r.ok   = 1'b0;
            r.code = DEP_1B;
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/mce_depth_cfg.sv
module mce_depth_cfg
   import mce_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cfg_we,
   input  logic [5:0] cfg_bpp,
   input  logic       line_busy,
   output depth_e     depth,
   output logic       reject
);
   bpp_dec_t dec;
   assign dec = decode_bpp(cfg_bpp);

   always_ff @(posedge clk) begin
      if (rst) begin
         depth  <= DEP_1B;
         reject <= 1'b0;
      end else begin
         reject <= cfg_we && (line_busy || !dec.ok);
         if (cfg_we && !line_busy && dec.ok)
            depth <= dec.code;
      end
   end
endmodule

// File: rtl/mce_bit_replicate.sv
module mce_bit_replicate
   import mce_pkg::*;
(
   input  logic [7:0]           bits,
   input  depth_e               depth,
   output logic [MASK_BITS-1:0] mask
);
   logic [MASK_BITS-1:0] cand [MAX_BYTES];

   for (genvar d = 0; d < MAX_BYTES; d++) begin : g_dep
      localparam int B = d + 1;
      logic [MASK_BITS-1:0] w;
      for (genvar j = 0; j < 8; j++) begin : g_bit
         assign w[j*B +: B] = {B{bits[j]}};
      end
      if (8 * B < MASK_BITS) begin : g_pad
         assign w[MASK_BITS-1:8*B] = '0;
      end
      assign cand[d] = w;
   end

   assign mask = cand[depth];
endmodule

// File: rtl/mce_line_seq.sv
module mce_line_seq
   import mce_pkg::*;
#(
   parameter int WIDTH_W   = 12,
   parameter int WORD_BITS = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               line_start,
   input  logic [WIDTH_W-1:0] line_width,
   input  depth_e             depth,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   output logic               in_ready,
   input  logic               out_ready,
   output logic               out_valid,
   output logic               out_last,
   output logic [7:0]         held_byte,
   output logic [1:0]         sub_idx,
   output logic               busy
);
   localparam int WORD_BYTES = WORD_BITS / 8;
   localparam int CNT_W      = WIDTH_W + 1;
   localparam int WSH        = $clog2(WORD_BITS);
   localparam int BSH        = $clog2(WORD_BYTES);

   logic [CNT_W-1:0] padded, line_bytes, in_left_q;
   logic             busy_q, hold_q, final_q;
   logic [7:0]       byte_q;
   logic [1:0]       sub_q;
   logic             sub_last, emit, drain, take;

   assign padded     = {1'b0, line_width} + CNT_W'(WORD_BITS - 1);
   assign line_bytes = (padded >> WSH) << BSH;

   assign sub_last = (sub_q == 2'(depth));
   assign emit     = hold_q && out_ready;
   assign drain    = emit && sub_last;
   assign in_ready = busy_q && (in_left_q != '0) && (!hold_q || drain);
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q    <= 1'b0;
         hold_q    <= 1'b0;
         final_q   <= 1'b0;
         in_left_q <= '0;
         sub_q     <= '0;
         byte_q    <= '0;
      end else begin
         if (!busy_q && line_start && line_bytes != '0) begin
            busy_q    <= 1'b1;
            in_left_q <= line_bytes;
         end
         if (take) begin
            byte_q    <= in_data;
            hold_q    <= 1'b1;
            sub_q     <= '0;
            final_q   <= (in_left_q == CNT_W'(1));
            in_left_q <= in_left_q - CNT_W'(1);
         end else if (emit) begin
            if (sub_last) begin
               hold_q <= 1'b0;
               if (final_q) begin
                  busy_q  <= 1'b0;
                  final_q <= 1'b0;
               end
            end else begin
               sub_q <= sub_q + 2'd1;
            end
         end
      end
   end

   assign out_valid = hold_q;
   assign out_last  = hold_q && sub_last && final_q;
   assign held_byte = byte_q;
   assign sub_idx   = sub_q;
   assign busy      = busy_q;
endmodule

// File: rtl/mono_color_expander.sv
module mono_color_expander
   import mce_pkg::*;
#(
   parameter int WIDTH_W   = 12,
   parameter int WORD_BITS = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [5:0]         cfg_bpp,
   output logic               cfg_reject,
   input  logic               line_start,
   input  logic [WIDTH_W-1:0] line_width,
   output logic               busy,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [7:0]         out_data,
   output logic               out_last,
   input  logic               out_ready
);
   if (WORD_BITS < 8 || (WORD_BITS & (WORD_BITS - 1)) != 0) begin : g_bad_word
      $error("WORD_BITS must be a power of two of at least 8");
   end
   if (WIDTH_W < 2 || WIDTH_W > 24) begin : g_bad_width
      $error("WIDTH_W out of range");
   end

   depth_e               depth;
   logic [7:0]           held_byte;
   logic [1:0]           sub_idx;
   logic [MASK_BITS-1:0] mask;

   mce_depth_cfg u_cfg (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bpp(cfg_bpp),
      .line_busy(busy), .depth(depth), .reject(cfg_reject)
   );

   mce_line_seq #(.WIDTH_W(WIDTH_W), .WORD_BITS(WORD_BITS)) u_seq (
      .clk(clk), .rst(rst), .line_start(line_start), .line_width(line_width),
      .depth(depth), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
      .held_byte(held_byte), .sub_idx(sub_idx), .busy(busy)
   );

   mce_bit_replicate u_rep (
      .bits(held_byte), .depth(depth), .mask(mask)
   );

   assign out_data = mask[8*sub_idx +: 8];
endmodule

// File: rtl/mce_checker.sv
module mce_checker (
   input logic       clk,
   input logic       rst,
   input logic       cfg_we,
   input logic       cfg_reject,
   input logic       busy,
   input logic       in_ready,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic       out_last,
   input logic       out_ready
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> !out_valid && !busy && !cfg_reject);

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   assert_last_qualified_R6: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid);

   assert_last_ends_line_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && out_last |=> !busy);

   assert_busy_cfg_rejected_R8: assert property (@(posedge clk) disable iff (rst)
      cfg_we && busy |=> cfg_reject);

   assert_ready_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> busy);
endmodule

bind mono_color_expander mce_checker u_chk (
   .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_reject(cfg_reject),
   .busy(busy), .in_ready(in_ready), .out_valid(out_valid),
   .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
);

// File: tb/mono_color_expander_test.sv
`timescale 1ns/1ps
module mono_color_expander_test;
   localparam int WW = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_bpp = '0;
   logic          cfg_reject;
   logic          line_start = 1'b0;
   logic [WW-1:0] line_width = '0;
   logic          busy;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_ready;
   logic          out_valid;
   logic [7:0]    out_data;
   logic          out_last;
   logic          out_ready = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   mono_color_expander #(.WIDTH_W(WW), .WORD_BITS(32)) uut (.*);

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [7:0] v, input int b, input int k);
      logic [31:0] e = '0;
      for (int j = 0; j < 8; j++)
         for (int m = 0; m < b; m++)
            e[j*b+m] = v[j];
      return e[8*k +: 8];
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // R1: reset state
   task automatic t_reset();
      do_reset();
      #1;
      check(!out_valid && !out_last, "R1 out idle", out_valid, 0);
      check(!busy && !in_ready, "R1 busy/ready", {busy, in_ready}, 0);
      check(!cfg_reject, "R1 reject", cfg_reject, 0);
   endtask

   // R2 / R8: configuration write and registered reject flag
   task automatic t_cfg(input int bpp, input bit exp_rej);
      @(negedge clk);
      cfg_we  = 1'b1;
      cfg_bpp = 6'(bpp);
      @(negedge clk);
      cfg_we  = 1'b0;
      #1;
      check(cfg_reject == exp_rej, "R2 cfg reject", cfg_reject, exp_rej);
   endtask

   // Runs one scanline and checks every output byte.
   // bp: 0 always ready, 1 stalls; act: 0 none, 1 cfg while busy (R8), 2 start while busy (R9)
   task automatic t_line(input int width, input int b, input int bp, input int act, input int seed);
      logic [7:0] din [64];
      int n_in, n_out, idx, oc, cyc;
      bit prev_stall;
      logic [7:0] prev_data;
      logic prev_last;
      n_in  = ((width + 31) / 32) * 4;
      n_out = n_in * b;
      for (int i = 0; i < n_in; i++) din[i] = 8'((i * 37 + seed * 11 + 5) ^ (i << 4));
      din[0] = 8'hA5;
      @(negedge clk);
      line_start = 1'b1;
      line_width = WW'(width);
      @(negedge clk);
      line_start = 1'b0;
      idx = 0; oc = 0; cyc = 0; prev_stall = 0; prev_data = '0; prev_last = 0;
      while (oc < n_out && cyc < 2000) begin
         in_valid  = (idx < n_in);
         in_data   = (idx < n_in) ? din[idx] : 8'h00;
         out_ready = (bp == 0) ? 1'b1 : ((cyc % 3) != 1);
         if (act == 1 && cyc == 3) begin cfg_we = 1'b1; cfg_bpp = 6'd8; end
         if (act == 2 && cyc == 3) begin line_start = 1'b1; line_width = WW'(200); end
         #1;
         if (act == 1 && cyc == 4)
            check(cfg_reject == 1'b1, "R8 busy cfg flagged", cfg_reject, 1);
         if (prev_stall) begin
            check(out_valid && out_data == prev_data && out_last == prev_last,
                  "R7 held under stall", out_data, prev_data);
         end
         if (out_valid && out_ready) begin
            check(out_data == exp_byte(din[oc / b], b, oc % b), "R3 mask byte",
                  out_data, exp_byte(din[oc / b], b, oc % b));
            check(out_last == (oc == n_out - 1), "R6 last marker", out_last, oc == n_out - 1);
            oc++;
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_last  = out_last;
         if (in_valid && in_ready) idx++;
         @(negedge clk);
         cfg_we = 1'b0;
         line_start = 1'b0;
         cyc++;
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      #1;
      check(oc == n_out, "R4 output byte count", oc, n_out);
      check(idx == n_in, "R5 input byte count", idx, n_in);
      check(!busy && !out_valid, "R6 line ended", busy, 0);
      check(!in_ready, "R11 no ready when idle", in_ready, 0);
   endtask

   // R5: zero width starts nothing
   task automatic t_zero();
      @(negedge clk);
      line_start = 1'b1;
      line_width = '0;
      @(negedge clk);
      line_start = 1'b0;
      #1;
      check(!busy && !in_ready, "R5 zero width idle", busy, 0);
   endtask

   // R10: reset mid-line
   task automatic t_mid_reset();
      @(negedge clk);
      line_start = 1'b1;
      line_width = WW'(64);
      @(negedge clk);
      line_start = 1'b0;
      in_valid = 1'b1;
      in_data = 8'hFF;
      out_ready = 1'b0;
      @(negedge clk);
      #1;
      check(out_valid, "R10 partial present", out_valid, 1);
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(!out_valid && !busy && !in_ready, "R10 dropped by reset",
            {out_valid, busy, in_ready}, 0);
      out_ready = 1'b1;
   endtask

   initial begin
      t_reset();
      t_line(40, 1, 0, 0, 1);     // R3 R4 R5 default depth 1
      t_cfg(16, 0);
      t_line(33, 2, 0, 0, 2);     // R2 depth 2
      t_cfg(15, 0);
      t_line(64, 2, 1, 0, 3);     // R2 15 as 16, R7
      t_cfg(24, 0);
      t_line(20, 3, 1, 0, 4);     // R4 three-byte case, R7
      t_cfg(32, 0);
      t_line(32, 4, 0, 0, 5);     // R3 depth 4
      t_cfg(12, 1);               // R2 unsupported rejected
      t_line(16, 4, 0, 0, 6);     // R2 depth unchanged
      t_line(40, 4, 1, 1, 7);     // R8 cfg while busy ignored
      t_line(8, 4, 0, 2, 8);      // R9 start while busy ignored
      t_zero();
      t_mid_reset();
      t_line(8, 1, 0, 0, 9);      // R10 R1 fresh line at reset depth
      summary();
      $finish;
   end
endmodule